// File: doc/BRIEF.md
# Reloading Down-Counter Timer with APB Access

This block is a peripheral timer that sits on an APB slave port. A count register steps down by one on every counting tick while the timer is enabled. When the count steps from 1 to 0, an interrupt status bit is set, provided that interrupts are enabled. The count then stays at 0 for one further tick and loads the value held in a reload register on the tick after that. Software can set the count directly, or load the count and the reload value together through a single write. The single interrupt output is a level that follows the status bit until software clears the bit.

A counting tick normally comes from every bus clock. An external input, first passed through a synchronizer, can take over that role in either of two ways. As a gate, it allows ticks only while it is high. As a slow clock, each rising edge gives exactly one tick. The upper end of the 4 KB register window holds twelve read-only identification words. Every transfer completes in its access cycle with no error response.

The counter runs a three-state machine. `ST_HALT` is the state while the enable bit is clear. `ST_DOWN` is the state while the count is nonzero. `ST_EXPIRED` is the state while the count is zero and the next tick will reload it. Each cycle follows one of these transitions:
- Any state goes to HALT when enable is clear.
- HALT goes to DOWN or EXPIRED once enable is set, depending on the count.
- DOWN goes to EXPIRED on the 1-to-0 tick, which is the *expire* transition.
- EXPIRED goes to DOWN on the *reload* transition when the reload value is nonzero, and stays in EXPIRED when it is zero.
- A software load goes to DOWN or EXPIRED according to the written value.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset, the control, count, reload and status registers all read 0, and `irq` is low.
- R2: The control register is at offset 0x000. Bit 0 is run enable, bit 1 selects the external gate, bit 2 selects the external clock, and bit 3 is interrupt enable. Only bits 3:0 are stored, and all other bits read 0.
- R3: While run enable is set and no external mode is selected, the count drops by one per clock. While run enable is clear, the count does not change.
- R4: The status bit becomes 1 only on a tick that takes the count from 1 to 0 while interrupt enable is set. The `irq` output equals the status bit.
- R5: After the count reaches 0, it stays at 0 for one tick and loads the reload value on the next tick.
- R6: With a reload value of 0, the count stays at 0 after expiring, and no further interrupt is raised.
- R7: A write to offset 0x008 sets both the reload register and the count. A write to offset 0x004 sets only the count. A software load takes priority over a tick in the same cycle.
- R8: The status register is at offset 0x00C, bit 0. Writing 1 to it clears the bit, and writing 0 has no effect. A set in the same cycle wins over a clear.
- R9: When the external gate is selected, ticks occur only while the synchronized external input is high.
- R10: When the external clock is selected, each synchronized rising edge of the external input gives one tick. The external clock takes priority over the external gate.
- R11: The words at 0xFD0 through 0xFFC read, in address order, 04 00 00 00 22 B8 1B 00 0D F0 05 B1. Writes to these words are ignored, and unmapped offsets read 0.
- R12: The count and reload registers are `CNT_W` bits wide. Written data above that width is dropped, and reads are zero-extended.
- R13: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, 0 when not selected |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| ext_in | input | 1 | Asynchronous external gate or clock |
| irq | output | 1 | Level interrupt, equals the status bit |

## Verification
The bench instantiates the timer with `CNT_W` = 16 and two synchronizer stages. The narrower counter makes the truncation of wide written values observable at the ports (R12). Two synchronizer stages are the shortest setting, which keeps the delay from the external input to the tick easy to predict for the gate and clock modes. The reference model in the bench tracks every register and the synchronizer delay on each clock. It is compared with `irq` on every cycle and with every value read back, which covers the reload hold, the behaviour with a reload value of 0, and the set-over-clear priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'hFD0;

    localparam int CTL_RUN    = 0;
    localparam int CTL_GATE   = 1;
    localparam int CTL_EXTCLK = 2;
    localparam int CTL_IRQEN  = 3;
    localparam int CTL_W      = 4;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_DOWN    = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;

    function automatic logic [7:0] ident_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h22;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic run_en,
    input  logic gate_sel,
    input  logic extclk_sel,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_lvl;
    logic                   ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_in;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    assign ext_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ext_lvl;
    end

    assign ext_rise = ext_lvl & ~prev_q;

    always_comb begin
        if (!run_en)         tick = 1'b0;
        else if (extclk_sel) tick = ext_rise;
        else if (gate_sel)   tick = ext_lvl;
        else                 tick = 1'b1;
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             irq_en,
    input  logic             tick,
    input  logic             ld_valid,
    input  logic [CNT_W-1:0] ld_data,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (ld_valid) begin
            cnt_d = ld_data;
        end else if (tick) begin
            unique case (state_q)
                ST_DOWN: begin
                    if (cnt_q == ONE) begin
                        cnt_d  = '0;
                        expire = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                ST_EXPIRED: cnt_d = reload_val;
                ST_HALT: begin
                    if (cnt_q == '0) begin
                        cnt_d = reload_val;
                    end else if (cnt_q == ONE) begin
                        cnt_d  = '0;
                        expire = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
        if (!run_en)           state_d = ST_HALT;
        else if (cnt_d == '0)  state_d = ST_EXPIRED;
        else                   state_d = ST_DOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                irq_o <= 1'b0;
        else if (expire && irq_en) irq_o <= 1'b1;
        else if (clr_req)          irq_o <= 1'b0;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              irq_i,
    output logic [CTL_W-1:0]  ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              ld_valid,
    output logic [CNT_W-1:0]  ld_data,
    output logic              clr_req
);

    logic       wr_en;
    logic       in_ident;
    logic [3:0] ident_idx;

    assign wr_en     = psel & penable & pwrite;
    assign ld_valid  = wr_en & ((paddr == OFS_COUNT) | (paddr == OFS_RELOAD));
    assign ld_data   = pwdata[CNT_W-1:0];
    assign clr_req   = wr_en & (paddr == OFS_STATUS) & pwdata[0];
    assign in_ident  = (paddr >= OFS_IDENT) & (paddr[1:0] == 2'b00);
    assign ident_idx = paddr[5:2] - 4'd4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (paddr == OFS_CTRL)   ctrl_q   <= pwdata[CTL_W-1:0];
            if (paddr == OFS_RELOAD) reload_q <= pwdata[CNT_W-1:0];
        end
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            if (in_ident) begin
                prdata[7:0] = ident_byte(ident_idx);
            end else begin
                unique case (paddr)
                    OFS_CTRL:   prdata[CTL_W-1:0] = ctrl_q;
                    OFS_COUNT:  prdata[CNT_W-1:0] = cnt_i;
                    OFS_RELOAD: prdata[CNT_W-1:0] = reload_q;
                    OFS_STATUS: prdata[0]         = irq_i;
                    default:    prdata            = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    input  logic        ext_in,
    output logic        irq
);

    logic [CTL_W-1:0] ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ld_data;
    logic             ld_valid;
    logic             clr_req;
    logic             tick;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    tmr_apb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cnt_i(cnt), .irq_i(irq),
        .ctrl_q(ctrl_q), .reload_q(reload_q),
        .ld_valid(ld_valid), .ld_data(ld_data), .clr_req(clr_req)
    );

    tmr_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(pclk), .rst_n(presetn), .ext_in(ext_in),
        .run_en(ctrl_q[CTL_RUN]), .gate_sel(ctrl_q[CTL_GATE]),
        .extclk_sel(ctrl_q[CTL_EXTCLK]), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(pclk), .rst_n(presetn),
        .run_en(ctrl_q[CTL_RUN]), .irq_en(ctrl_q[CTL_IRQEN]),
        .tick(tick), .ld_valid(ld_valid), .ld_data(ld_data),
        .reload_val(reload_q), .clr_req(clr_req),
        .cnt_o(cnt), .irq_o(irq)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ld_valid,
    input logic [CNT_W-1:0] ld_data,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload_q,
    input logic             irq_en,
    input logic             clr_req,
    input logic             irq
);

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_valid && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3

    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_valid) |=> $stable(cnt)); // R3

    AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_valid && cnt == CNT_W'(1) && irq_en) |=> irq); // R4

    AST_IRQ_ONLY_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick && !ld_valid && cnt == CNT_W'(1) && irq_en)); // R4

    AST_RELOAD_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_valid && cnt == '0) |=> (cnt == $past(reload_q))); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (cnt == $past(ld_data))); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(tick && !ld_valid && cnt == CNT_W'(1) && irq_en)) |=> !irq); // R8

endmodule

bind apb_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(pclk), .rst_n(presetn), .tick(tick), .ld_valid(ld_valid),
    .ld_data(ld_data), .cnt(cnt), .reload_q(reload_q),
    .irq_en(ctrl_q[3]), .clr_req(clr_req), .irq(irq)
);

// File: tb/apb_reload_timer_test.sv
`timescale 1ns/1ps
module apb_reload_timer_test;

    localparam int CW = 16;
    localparam logic [31:0] MASK = (32'h1 << CW) - 32'h1;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;
    logic        ext_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0] m_ctrl, m_cnt, m_reload;
    logic        m_irq, m_s1, m_s2, m_prev;

    always #2 pclk = ~pclk;

    apb_reload_timer #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
    );

    function automatic logic [31:0] id_word(input int i);
        logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                               8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return {24'h0, t[i]};
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h000) return m_ctrl;
        if (a == 12'h004) return m_cnt;
        if (a == 12'h008) return m_reload;
        if (a == 12'h00C) return {31'h0, m_irq};
        if (a >= 12'hFD0 && a[1:0] == 2'b00) return id_word((int'(a) - 'hFD0) / 4);
        return 32'h0;
    endfunction

    always @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            m_ctrl = 0; m_cnt = 0; m_reload = 0; m_irq = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            bit t, fire, wr;
            logic [31:0] nc, nr, nctl;
            logic ni;
            wr = psel && penable && pwrite;
            if (!m_ctrl[0])     t = 0;
            else if (m_ctrl[2]) t = m_s2 && !m_prev;
            else if (m_ctrl[1]) t = m_s2;
            else                t = 1;
            fire = 0; nc = m_cnt; nr = m_reload; nctl = m_ctrl; ni = m_irq;
            if (wr && (paddr == 12'h004 || paddr == 12'h008)) nc = pwdata & MASK;
            else if (t) begin
                if (m_cnt == 0)      nc = m_reload;
                else if (m_cnt == 1) begin nc = 0; fire = 1; end
                else                 nc = m_cnt - 1;
            end
            if (wr && paddr == 12'h000) nctl = pwdata & 32'hF;
            if (wr && paddr == 12'h008) nr = pwdata & MASK;
            if (fire && m_ctrl[3]) ni = 1;
            else if (wr && paddr == 12'h00C && pwdata[0]) ni = 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_in;
            m_cnt = nc; m_reload = nr; m_ctrl = nctl; m_irq = ni;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every cycle: interrupt output against model (R4, R8)
    always @(negedge pclk) begin
        if (presetn) chk(irq === m_irq, "R4", {31'h0, irq}, {31'h0, m_irq});
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, input string req, output logic [31:0] got);
        logic [31:0] exp;
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1;
        got = prdata; exp = model_read(a);
        chk(got === exp, req, got, exp);
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v1, v2, v3;
        repeat (4) @(negedge pclk);
        presetn = 1;

        // R1 reset state
        rd(12'h000, "R1", v1); rd(12'h004, "R1", v1);
        rd(12'h008, "R1", v1); rd(12'h00C, "R1", v1);
        chk(irq === 1'b0, "R1", {31'h0, irq}, 0);
        chk(pready === 1'b1 && pslverr === 1'b0, "R13", {pready, pslverr}, 2'b10);

        // R2 control storage
        wr(12'h000, 32'hFFFF_FFF0); rd(12'h000, "R2", v1);
        chk(v1 == 0, "R2", v1, 0);
        wr(12'h000, 32'hFFFF_FFF6); rd(12'h000, "R2", v1);
        chk(v1 == 6, "R2", v1, 6);
        wr(12'h000, 0);

        // R7 reload write sets count too
        wr(12'h008, 6);
        rd(12'h008, "R7", v1); rd(12'h004, "R7", v2);
        chk(v2 == 6, "R7", v2, 6);

        // R3/R4/R5 free running with interrupt enabled
        wr(12'h000, 9);
        for (int i = 0; i < 12; i++) rd(12'h004, "R5", v1);
        chk(irq === 1'b1, "R4", {31'h0, irq}, 1);

        // R8 write 0 has no effect, write 1 clears
        wr(12'h00C, 0);
        chk(irq === 1'b1, "R8", {31'h0, irq}, 1);
        wr(12'h00C, 1);
        rd(12'h00C, "R8", v1);

        // R3 disabled holds
        wr(12'h000, 8);
        rd(12'h004, "R3", v1); idle(6); rd(12'h004, "R3", v2);
        chk(v1 == v2, "R3", v2, v1);

        // R6 reload zero
        wr(12'h000, 9); wr(12'h008, 0); wr(12'h00C, 1);
        idle(30);
        rd(12'h004, "R6", v1);
        chk(v1 == 0 && irq === 1'b0, "R6", {v1[30:0], irq}, 0);

        // R7 value write only, then expire once with reload 0
        wr(12'h004, 3); idle(8);
        chk(irq === 1'b1, "R7", {31'h0, irq}, 1);
        rd(12'h008, "R7", v1);
        wr(12'h00C, 1); idle(20);
        chk(irq === 1'b0, "R6", {31'h0, irq}, 0);

        // R9 external gate
        ext_in = 0;
        wr(12'h008, 100); wr(12'h000, 32'hB); idle(4);
        rd(12'h004, "R9", v1); idle(10); rd(12'h004, "R9", v2);
        chk(v1 == v2, "R9", v2, v1);
        ext_in = 1; idle(10);
        rd(12'h004, "R9", v3);
        chk(v3 < v2, "R9", v3, v2);

        // R10 external clock, priority over gate
        wr(12'h000, 32'hF);
        rd(12'h004, "R10", v1); idle(10); rd(12'h004, "R10", v2);
        chk(v1 == v2, "R10", v2, v1);
        for (int i = 0; i < 5; i++) begin
            @(negedge pclk) ext_in = 0; idle(4);
            @(negedge pclk) ext_in = 1; idle(4);
        end
        idle(4);
        rd(12'h004, "R10", v3);
        chk(v3 == v2 - 5, "R10", v3, v2 - 5);

        // R11 identification and unmapped
        for (int i = 0; i < 12; i++) rd(12'hFD0 + 12'(4 * i), "R11", v1);
        wr(12'hFD0, 32'hFF); rd(12'hFD0, "R11", v1);
        chk(v1 == 32'h04, "R11", v1, 32'h04);
        rd(12'h010, "R11", v1); rd(12'h800, "R11", v1);

        // R12 width truncation
        wr(12'h000, 0);
        wr(12'h008, 32'h0001_2345); rd(12'h008, "R12", v1);
        chk(v1 == 32'h2345, "R12", v1, 32'h2345);

        chk(pready === 1'b1 && pslverr === 1'b0, "R13", {pready, pslverr}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule